// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Write-Through

This block is a direct-mapped cache that sits between a processor and a slower memory. Addresses are 32-bit byte addresses, and each line holds four 32-bit words. On the processor side there is a word-wide request port with a stall output. On the memory side there is a request/acknowledge port. A memory read returns a whole 128-bit line. A memory write carries a single word. The number of lines is set by the index width parameter, which defaults to 12 bits (4096 lines).

The processor drives `cpu_req` and holds the request steady for as long as `cpu_stall` is high. A request completes at the rising edge where `cpu_req` is high and `cpu_stall` is low. A read hit completes in the cycle it is presented, and its data appears combinationally on `cpu_rdata`. A read miss fetches the line and installs it. The held load then completes as a hit in the next cycle.

Every write goes through to memory. A write hit also updates the cached word. For a write miss, the `ALLOCATE` parameter selects the policy:
- With `ALLOCATE` = 1, the line is first fetched, the store word is merged into it, and the merged line is installed before the word write.
- With `ALLOCATE` = 0, only memory is written and the cache is left unchanged.

Control is a three-state machine:
- **ST_IDLE** performs the lookup. It moves to ST_FILL on a read miss or on a write miss with `ALLOCATE` = 1. It moves to ST_WRITE on a write hit or on a write miss with `ALLOCATE` = 0.
- **ST_FILL** holds a line read. On acknowledge it installs the line, then goes to ST_WRITE for an allocating store or back to ST_IDLE for a load.
- **ST_WRITE** holds a word write. On acknowledge it returns to ST_IDLE, and it updates the cached word if the line is present.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_stall` and `mem_req` are low with no request, and the first access to any address is a miss.
- R2: The address fields are tag = bits 31..16, line index = bits 15..4, word-in-line = bits 3..2 and byte = bits 1..0. The byte bits never change the result. A hit requires the line's valid bit to be set and its stored tag to equal the address tag.
- R3: On a read hit, `cpu_rdata` carries word k of the line, taken from line bits 32k+31..32k where k = address bits 3..2. It is valid in the same cycle with `cpu_stall` low, and no memory request is made.
- R4: On a read miss, `cpu_stall` rises in the cycle the miss is seen. One memory read is issued with `mem_we` = 0 at the line-aligned address (bits 3..0 zero). The returned line is installed, and `cpu_stall` stays high through the acknowledge cycle. The load then completes as a hit, so the stall lasts one cycle more than the memory's response time.
- R5: On a write hit, exactly one memory write is issued with `mem_we` = 1, the word-aligned address (bits 1..0 zero) and the store data. `cpu_stall` falls in the acknowledge cycle. Later reads of that word hit and return the new data.
- R6: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the cycle the request rises until the cycle `mem_ack` is seen, and `mem_ack` completes exactly one transfer.
- R7: With `ALLOCATE` = 0, a write miss issues only one word write and leaves the cache unchanged, so a later read of that address misses and returns the written data.
- R8: With `ALLOCATE` = 1, a write miss first reads the line, then installs it with the store word merged in, then issues the word write. Later reads of any word in that line hit, and each returns either the stored word or the fetched memory word.
- R9: Two addresses with the same index and different tags evict each other, so alternating between them misses every time.
- R10: Once a miss or write has started, changes on `cpu_addr`, `cpu_wdata` and `cpu_we` are ignored. The memory transfer and the cache update use the values captured when the request was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load completes |
| cpu_stall | output | 1 | Request not yet complete; hold inputs |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | 32 | Line-aligned (read) or word-aligned (write) address |
| mem_wdata | output | 32 | Word to write |
| mem_rdata | input | 128 | Line returned by memory, word k in bits 32k+31..32k |
| mem_ack | input | 1 | One-cycle completion of the current transfer |

## Verification
The bench goes after the corner cases one by one:
- **Word selection:** It reads every word of a filled line and also uses non-zero byte offsets. A design with a wrong word multiplexer or a wrong offset slice returns a neighbouring word.
- **Index conflicts:** It alternates between two tags on the same index, including the top index with an all-ones tag. A design that compares the tag poorly reports false hits and returns stale data.
- **Allocating store miss:** It checks both halves of the merged line. A design that skips the merge, or merges into the wrong word, reads back either the stale memory word or a clobbered neighbour.
- **Non-allocating store miss:** It checks that the next load still misses. A design that installs the line anyway, or fails to write through, shows the wrong stall length or the wrong data.
- **Inputs changed while stalled:** It changes the processor inputs in the middle of a stall. A design that reads them live sends the wrong address or data to memory.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
    parameter int INDEX_W = 12,
    parameter int TAG_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0]   rd_tag,
    output logic               hit,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign hit = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);

    // R4: an installed line is valid with its new tag on the next cycle
    p_install_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
    parameter int INDEX_W    = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic                         clk,
    input  logic [INDEX_W-1:0]           rd_idx,
    output logic [WORD_W*LINE_WORDS-1:0] rd_line,
    input  logic                         line_we,
    input  logic                         word_we,
    input  logic [INDEX_W-1:0]           wr_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_sel,
    input  logic [WORD_W*LINE_WORDS-1:0] wr_line,
    input  logic [WORD_W-1:0]            wr_word
);
    localparam int LINES = 1 << INDEX_W;
    localparam int SEL_W = $clog2(LINE_WORDS);

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
        logic [WORD_W-1:0] lane_mem [LINES];
        logic              pick;

        assign pick = word_we && (wr_sel == SEL_W'(w));

        always_ff @(posedge clk) begin
            if (pick) begin
                lane_mem[wr_idx] <= wr_word;
            end else if (line_we) begin
                lane_mem[wr_idx] <= wr_line[w*WORD_W +: WORD_W];
            end
        end

        assign rd_line[w*WORD_W +: WORD_W] = lane_mem[rd_idx];
    end
endmodule

// File: rtl/dmc_word_mux.sv
module dmc_word_mux #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic [WORD_W*LINE_WORDS-1:0]  line,
    input  logic [$clog2(LINE_WORDS)-1:0] sel,
    output logic [WORD_W-1:0]             word
);
    logic [WORD_W-1:0] slots [LINE_WORDS];

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_slot
        assign slots[w] = line[w*WORD_W +: WORD_W];
    end

    assign word = slots[sel];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter bit ALLOCATE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       lk_hit,
    input  logic       cap_we,
    input  logic       mem_ack,
    output dmc_state_e state,
    output logic       cpu_stall,
    output logic       mem_req,
    output logic       mem_we,
    output logic       cap_en,
    output logic       fill_we,
    output logic       word_we
);
    dmc_state_e state_q, state_d;

    assign state = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cpu_stall = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        cap_en    = 1'b0;
        fill_we   = 1'b0;
        word_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we) begin
                    cpu_stall = 1'b1;
                    cap_en    = 1'b1;
                    state_d   = (lk_hit || !ALLOCATE) ? ST_WRITE : ST_FILL;
                end else if (cpu_req && !lk_hit) begin
                    cpu_stall = 1'b1;
                    cap_en    = 1'b1;
                    state_d   = ST_FILL;
                end
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                if (mem_ack) begin
                    fill_we = 1'b1;
                    state_d = cap_we ? ST_WRITE : ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                cpu_stall = !mem_ack;
                if (mem_ack) begin
                    word_we = lk_hit;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R10: while a transfer is outstanding the processor is held off
    p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !mem_ack) |-> cpu_stall);

    // R4: a load miss leads to a line read
    p_rmiss_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !cpu_we && !lk_hit) |=>
        (state_q == ST_FILL && mem_req && !mem_we));

    // R7: a store miss follows the chosen allocation policy
    p_wmiss_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && cpu_we && !lk_hit) |=>
        (state_q == (ALLOCATE ? ST_FILL : ST_WRITE)));

    // R8: an allocating fill is followed by the word write
    p_alloc_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ack && cap_we) |=> (state_q == ST_WRITE && mem_we));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int INDEX_W    = 12,
    parameter bit ALLOCATE   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [WORD_W-1:0]            cpu_wdata,
    output logic [WORD_W-1:0]            cpu_rdata,
    output logic                         cpu_stall,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [WORD_W-1:0]            mem_wdata,
    input  logic [WORD_W*LINE_WORDS-1:0] mem_rdata,
    input  logic                         mem_ack
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int LO     = BYTE_W + OFF_W;
    localparam int TAG_W  = ADDR_W - INDEX_W - LO;
    localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-LO){1'b1}}, {LO{1'b0}}};
    localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};

    dmc_state_e          state;
    logic                cap_en, fill_we, ctl_word_we, lk_hit;
    logic [ADDR_W-1:0]   cap_addr;
    logic [WORD_W-1:0]   cap_wdata;
    logic                cap_we;
    logic [INDEX_W-1:0]  lk_idx, cap_idx;
    logic [TAG_W-1:0]    lk_tag, cap_tag;
    logic [OFF_W-1:0]    lk_off, cap_off;
    logic [WORD_W*LINE_WORDS-1:0] rd_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_we    <= 1'b0;
        end else if (cap_en) begin
            cap_addr  <= cpu_addr;
            cap_wdata <= cpu_wdata;
            cap_we    <= cpu_we;
        end
    end

    assign cap_idx = cap_addr[LO +: INDEX_W];
    assign cap_tag = cap_addr[ADDR_W-1 -: TAG_W];
    assign cap_off = cap_addr[BYTE_W +: OFF_W];

    // live address while idle, captured address while a transfer runs
    assign lk_idx = (state == ST_IDLE) ? cpu_addr[LO +: INDEX_W]       : cap_idx;
    assign lk_tag = (state == ST_IDLE) ? cpu_addr[ADDR_W-1 -: TAG_W]   : cap_tag;
    assign lk_off = (state == ST_IDLE) ? cpu_addr[BYTE_W +: OFF_W]     : cap_off;

    dmc_ctrl #(.ALLOCATE(ALLOCATE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .lk_hit    (lk_hit),
        .cap_we    (cap_we),
        .mem_ack   (mem_ack),
        .state     (state),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .cap_en    (cap_en),
        .fill_we   (fill_we),
        .word_we   (ctl_word_we)
    );

    dmc_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_tag (lk_tag),
        .hit    (lk_hit),
        .wr_en  (fill_we),
        .wr_idx (cap_idx),
        .wr_tag (cap_tag)
    );

    dmc_data_array #(.INDEX_W(INDEX_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_data (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_line (rd_line),
        .line_we (fill_we),
        .word_we (ctl_word_we | (fill_we & cap_we)),
        .wr_idx  (cap_idx),
        .wr_sel  (cap_off),
        .wr_line (mem_rdata),
        .wr_word (cap_wdata)
    );

    dmc_word_mux #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_mux (
        .line (rd_line),
        .sel  (lk_off),
        .word (cpu_rdata)
    );

    assign mem_addr  = cap_addr & (mem_we ? WORD_MASK : LINE_MASK);
    assign mem_wdata = cap_wdata;

    // R6: an unanswered request holds its attributes
    p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5: one acknowledged word write ends the store
    p_wt_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> !mem_req);

    // R3: a load hit never stalls and never reaches memory
    p_rhit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && !cpu_we && lk_hit) |-> (!cpu_stall && !mem_req));
endmodule

// File: tb/sim_dmc_cache.sv
`timescale 1ns/100ps
module sim_dmc_cache;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n, creq, cwe, sel, mack;
    logic [31:0]  caddr, cwdata;
    logic [127:0] mrdata;
    logic [31:0]  rdata0, rdata1, maddr0, maddr1, mwd0, mwd1;
    logic         stall0, stall1, mreq0, mreq1, mwe0, mwe1;

    dmc_cache #(.ALLOCATE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(creq & ~sel), .cpu_we(cwe),
        .cpu_addr(caddr), .cpu_wdata(cwdata), .cpu_rdata(rdata0), .cpu_stall(stall0),
        .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_wdata(mwd0),
        .mem_rdata(mrdata), .mem_ack(mack & ~sel));

    dmc_cache #(.ALLOCATE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_req(creq & sel), .cpu_we(cwe),
        .cpu_addr(caddr), .cpu_wdata(cwdata), .cpu_rdata(rdata1), .cpu_stall(stall1),
        .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_wdata(mwd1),
        .mem_rdata(mrdata), .mem_ack(mack & sel));

    wire        m_req  = sel ? mreq1 : mreq0;
    wire        m_we   = sel ? mwe1  : mwe0;
    wire [31:0] m_addr = sel ? maddr1 : maddr0;
    wire [31:0] m_wd   = sel ? mwd1  : mwd0;
    wire        c_stall = sel ? stall1 : stall0;
    wire [31:0] c_rdata = sel ? rdata1 : rdata0;

    typedef struct { bit we; logic [31:0] a; logic [31:0] d; } txn_t;
    txn_t        log_q[$];
    logic [31:0] shmem [logic [32:0]];
    bit          mval [int];
    logic [15:0] mtag [int];

    int n_tests = 0, n_fail = 0, rcnt = 0;
    bit unstable = 0, p_req = 0, p_ack = 0, p_we = 0;
    logic [31:0] p_addr = '0, p_wd = '0;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        if (shmem.exists({sel, a})) return shmem[{sel, a}];
        return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock: memory responder at the falling edge, then settle
    task automatic step();
        @(negedge clk);
        if (p_req && !p_ack && (!m_req || m_addr != p_addr || m_we != p_we || m_wd != p_wd))
            unstable = 1;
        if (mack) begin
            mack = 0;
            rcnt = 0;
        end else if (m_req) begin
            rcnt++;
            if (rcnt == LAT) begin
                mack = 1;
                log_q.push_back('{m_we, m_addr, m_wd});
                if (m_we) shmem[{sel, m_addr}] = m_wd;
                else for (int k = 0; k < 4; k++) mrdata[32*k +: 32] = mem_word(m_addr + 32'(4*k));
                chk(!unstable, "R6", "request held stable until ack", 128'(unstable), 128'd0);
                unstable = 0;
            end
        end
        p_req = m_req; p_ack = mack; p_we = m_we; p_addr = m_addr; p_wd = m_wd;
        #1;
    endtask

    task automatic access(bit we, logic [31:0] a, logic [31:0] d, bit wiggle, string req);
        int  key = int'(sel) * 4096 + int'(a[15:4]);
        bit  hit = mval.exists(key) && mval[key] && mtag[key] == a[31:16];
        bit  alloc = (sel == 0);
        int  exp_st, st = 0;
        int  exp_n;
        log_q.delete();
        if (!we) begin exp_st = hit ? 0 : 1 + LAT; exp_n = hit ? 0 : 1; end
        else if (hit || !alloc) begin exp_st = LAT; exp_n = 1; end
        else begin exp_st = 2 * LAT + 1; exp_n = 2; end
        creq = 1; cwe = we; caddr = a; cwdata = d;
        #1;
        while (c_stall && st < 200) begin
            st++;
            if (wiggle && st == 2) begin
                caddr = a ^ 32'h00F0_00F4; cwdata = ~d; cwe = ~we;
            end
            step();
        end
        if (!we)
            chk(c_rdata == mem_word({a[31:2], 2'b00}), req, $sformatf("load data @%h", a),
                128'(c_rdata), 128'(mem_word({a[31:2], 2'b00})));
        chk(st == exp_st, req, $sformatf("stall cycles @%h", a), 128'(st), 128'(exp_st));
        step();
        creq = 0; cwe = 0;
        chk(log_q.size() == exp_n, req, "memory transfer count", 128'(log_q.size()), 128'(exp_n));
        if (log_q.size() == exp_n) begin
            if (exp_n != 0 && !(we && (hit || !alloc)))
                chk(!log_q[0].we && log_q[0].a == {a[31:4], 4'h0}, req, "line read address",
                    128'(log_q[0].a), 128'({a[31:4], 4'h0}));
            if (we)
                chk(log_q[exp_n-1].we && log_q[exp_n-1].a == {a[31:2], 2'b00} && log_q[exp_n-1].d == d,
                    req, "word write addr/data", {log_q[exp_n-1].a, log_q[exp_n-1].d},
                    {{a[31:2], 2'b00}, d});
        end
        if (!hit && (!we || alloc)) begin
            mval[key] = 1;
            mtag[key] = a[31:16];
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] lf = 32'h1ACE_B00C;
        rst_n = 0; creq = 0; cwe = 0; sel = 0; mack = 0;
        caddr = '0; cwdata = '0; mrdata = '0;
        repeat (3) step();
        rst_n = 1;
        step();
        chk(!stall0 && !stall1 && !mreq0 && !mreq1, "R1", "idle after reset",
            {stall0, stall1, mreq0, mreq1}, 4'b0);

        // allocating instance
        access(0, 32'h0000_1230, 0, 0, "R1 R4");
        access(0, 32'h0000_1230, 0, 0, "R3");
        access(0, 32'h0000_1234, 0, 0, "R3");
        access(0, 32'h0000_1238, 0, 0, "R3");
        access(0, 32'h0000_123C, 0, 0, "R3");
        access(0, 32'h0000_1233, 0, 0, "R2");
        access(0, 32'h0005_1230, 0, 0, "R9");
        access(0, 32'h0000_1234, 0, 0, "R9");
        access(0, 32'h0005_1238, 0, 0, "R9");
        access(1, 32'h0005_1238, 32'hDEAD_BEEF, 0, "R5");
        access(0, 32'h0005_1238, 0, 0, "R5");
        access(1, 32'h0007_2346, 32'hCAFE_0001, 1, "R8 R10");
        access(0, 32'h0007_2344, 0, 0, "R8");
        access(0, 32'h0007_2340, 0, 0, "R8");
        access(0, 32'h0007_234C, 0, 0, "R8");
        access(0, 32'hFFFF_FFFC, 0, 0, "R2");
        access(0, 32'hFFFF_FFF1, 0, 0, "R2");

        // non-allocating instance
        sel = 1;
        step();
        access(1, 32'h0000_1230, 32'h1111_2222, 0, "R1 R7");
        access(0, 32'h0000_1230, 0, 0, "R7");
        access(1, 32'h0000_1230, 32'h3333_4444, 0, "R5");
        access(0, 32'h0000_1230, 0, 0, "R5");
        access(1, 32'h0003_0010, 32'h5555_6666, 1, "R7 R10");
        access(0, 32'h0003_0014, 0, 0, "R7 R10");

        // mixed traffic over a few conflicting lines
        for (int i = 0; i < 80; i++) begin
            logic [31:0] a;
            logic [11:0] ix;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = lf * 32'd1103515245 + 32'd12345;
            sel = lf[20];
            step();
            ix = (lf[9:8] == 2'd0) ? 12'h000 : (lf[9:8] == 2'd1) ? 12'h001 : 12'hFFF;
            a = {14'd0, lf[17:16], ix, lf[3:0]};
            access(lf[24], a, lf ^ 32'h0F0F_F0F0, 0, "R3 R4 R5 R9");
        end
        summary();
    end
endmodule